// File: doc/BRIEF.md
# Event-Qualified Bus Capture Memory

This block sits beside a 16-bit data bus and samples it whenever the sample enable is high. The sample enable is formed outside from system conditions and is assumed to be already qualified against the system clock. Every sampled word is compared against two programmable compare patterns, each with its own care mask. A selectable capture protocol then decides whether the word qualifies. A qualifying word is written into a 1024 x 16 capture memory when storing is enabled. It is also forwarded to a downstream signature stage when compression is enabled.

A host register port configures the protocol and the compare patterns and moves data in and out of the capture memory. The memory is reached through an address register and a data port. Every data-port access, read or write, advances the address by one, so a block of words moves with back-to-back accesses and no address rewrites. Capture only runs while the block is armed. Arming clears the write pointer and restarts the protocol.

The protocol engine is a state machine with five states:
- `ST_IDLE` means disarmed.
- `ST_WAIT` waits for a trigger match.
- `ST_RUN` applies the per-protocol store rule.
- `ST_COUNT` stores a fixed number of remaining words.
- `ST_DONE` means armed but finished.

Its transitions are:
- arm: any state to `ST_WAIT`, `ST_RUN` or `ST_DONE`, chosen by the protocol.
- disarm: any state to `ST_IDLE`.
- trigger: `ST_WAIT` to `ST_RUN`, or to `ST_COUNT` or `ST_DONE` for the counted protocol.
- stop: `ST_RUN` to `ST_DONE`.
- count-out: `ST_COUNT` to `ST_DONE`.

Top module: `bus_capture_core`

Host register map (4-bit `h_addr`):

| Address | Access | Contents |
|---|---|---|
| 0 | write | Control. Bits [2:0] protocol, bit 3 store enable, bit 4 compress enable, bit 14 disarm, bit 15 arm. Arm wins over disarm. |
| 1 | read | Status. Bit 15 armed, bit 14 full, bits [10:0] stored word count. |
| 2 | read/write | Host address, 10 bits. |
| 3 | read/write | Memory data port. |
| 4 | read/write | Pattern A value. |
| 5 | read/write | Pattern A care mask. |
| 6 | read/write | Pattern B value. |
| 7 | read/write | Pattern B care mask. |
| 8 | read/write | Word count N. |

Protocol codes: 0 all, 1 match-only, 2 start-on-match, 3 stop-on-match, 4 while-matching, 5 N-after-match, 6 window, 7 off.

## Requirements
- R1: After reset the block is disarmed. `cap_valid`, `sig_valid`, `full` and `sig_data` are 0, the status word reads 0, and both care masks are 0.
- R2: A word matches a pattern when (word XOR value) AND care is zero. Bits whose care bit is 0 never affect the match.
- R3: Under protocol 0, every word sampled while armed is stored at consecutive addresses starting from 0. `cap_valid` is high in the cycle after each stored sample.
- R4: Under protocol 1, only words matching pattern A are stored.
- R5: Under protocol 2, nothing is stored until the first pattern-A match. That match and every later sampled word are then stored.
- R6: Under protocol 3, sampled words are stored until the first pattern-A match. The matching word and everything after it are not stored.
- R7: Under protocol 4, storing begins at the first pattern-A match and continues while words match. It ends for good at the first non-matching word, which is not stored.
- R8: Under protocol 5, the first pattern-A match and the following sampled words are stored, N words in total. When N is 0 nothing is stored.
- R9: Under protocol 6, storing starts at a pattern-A match. It continues up to and including the first later word matching pattern B, then stops.
- R10: Under protocol 7, and at any time while disarmed, sampled words are neither stored nor forwarded.
- R11: `full` asserts once 1024 words are stored. Further qualifying words are not written and do not raise `cap_valid`.
- R12: Each data-port access (address 3) advances the host address by one, wrapping from 1023 to 0. Writes store the word at the current address, and reads return it combinationally.
- R13: Arming clears the stored word count and restarts the protocol, and a sample in the arming cycle is ignored. Host data-port writes while armed leave memory unchanged.
- R14: With compress enabled, each qualifying word appears on `sig_data` with `sig_valid` high in the following cycle. This holds regardless of store enable or `full`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and host clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_en | input | 1 | Qualified sample enable |
| bus_in | input | 16 | Monitored bus |
| h_sel | input | 1 | Host access strobe |
| h_wr | input | 1 | Host write (1) or read (0) |
| h_addr | input | 4 | Host register address |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data (combinational) |
| cap_valid | output | 1 | A word was stored in the previous cycle |
| full | output | 1 | Capture memory holds 1024 words |
| sig_valid | output | 1 | `sig_data` carries a qualifying word |
| sig_data | output | 16 | Word forwarded to the signature stage |

## Verification
A wrong protocol state shows at the ports one cycle after the first affected sample: `cap_valid` or `sig_valid` pulses when it should not, or stays low when it should pulse. A wrong write pointer is not visible on the pulse outputs. It surfaces when the status count is read or the memory is read back through the auto-incrementing data port. A wrong host address shows on the very next data-port read. A wrong full count shows as `full` rising at the wrong cycle.

// File: rtl/bcap_pkg.sv
`timescale 1ns/1ps
package bcap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RUN,
        ST_COUNT,
        ST_DONE
    } cap_state_t;

    typedef enum logic [2:0] {
        PR_ALL    = 3'd0,
        PR_MATCH  = 3'd1,
        PR_START  = 3'd2,
        PR_STOP   = 3'd3,
        PR_WHILE  = 3'd4,
        PR_COUNT  = 3'd5,
        PR_WINDOW = 3'd6,
        PR_OFF    = 3'd7
    } proto_t;

    localparam int NUM_PAT = 2;

    localparam logic [3:0] RA_CTRL     = 4'd0;
    localparam logic [3:0] RA_STAT     = 4'd1;
    localparam logic [3:0] RA_ADDR     = 4'd2;
    localparam logic [3:0] RA_DATA     = 4'd3;
    localparam logic [3:0] RA_PAT_BASE = 4'd4;
    localparam logic [3:0] RA_NCNT     = 4'd8;

    localparam int CTRL_STORE_BIT  = 3;
    localparam int CTRL_SIG_BIT    = 4;
    localparam int CTRL_DISARM_BIT = 14;
    localparam int CTRL_ARM_BIT    = 15;

    function automatic cap_state_t arm_state(input proto_t p);
        cap_state_t s;
        unique case (p)
            PR_START, PR_WHILE, PR_COUNT, PR_WINDOW: s = ST_WAIT;
            PR_OFF:                                  s = ST_DONE;
            default:                                 s = ST_RUN;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/bcap_match.sv
`timescale 1ns/1ps
module bcap_match #(
    parameter int DW = 16,
    parameter int NP = 2
) (
    input  logic [DW-1:0]         bus,
    input  logic [NP-1:0][DW-1:0] val,
    input  logic [NP-1:0][DW-1:0] care,
    output logic [NP-1:0]         hit
);

    for (genvar g = 0; g < NP; g++) begin : g_cmp
        assign hit[g] = ~|((bus ^ val[g]) & care[g]);
    end

endmodule

// File: rtl/bcap_proto_fsm.sv
`timescale 1ns/1ps
module bcap_proto_fsm
    import bcap_pkg::*;
#(
    parameter int CNTW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            arm,
    input  logic            disarm,
    input  proto_t          arm_proto,
    input  proto_t          proto,
    input  logic            smp,
    input  logic            hit_a,
    input  logic            hit_b,
    input  logic [CNTW-1:0] ncount,
    output logic            qual,
    output logic            armed
);

    cap_state_t      state, state_n;
    logic [CNTW-1:0] remain, remain_n;
    logic            step;

    assign step  = smp && !arm && !disarm;
    assign armed = (state != ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            remain <= '0;
        end else begin
            state  <= state_n;
            remain <= remain_n;
        end
    end

    // transitions
    always_comb begin
        state_n  = state;
        remain_n = remain;
        if (arm) begin
            state_n  = arm_state(arm_proto);
            remain_n = '0;
        end else if (disarm) begin
            state_n = ST_IDLE;
        end else if (step) begin
            unique case (state)
                ST_WAIT: begin
                    if (hit_a) begin
                        if (proto == PR_COUNT) begin
                            if (ncount <= CNTW'(1)) begin
                                state_n = ST_DONE;
                            end else begin
                                state_n  = ST_COUNT;
                                remain_n = ncount - CNTW'(1);
                            end
                        end else begin
                            state_n = ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    case (proto)
                        PR_STOP:   if (hit_a)  state_n = ST_DONE;
                        PR_WHILE:  if (!hit_a) state_n = ST_DONE;
                        PR_WINDOW: if (hit_b)  state_n = ST_DONE;
                        default: ;
                    endcase
                end
                ST_COUNT: begin
                    remain_n = remain - CNTW'(1);
                    if (remain == CNTW'(1)) state_n = ST_DONE;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        qual = 1'b0;
        if (step) begin
            unique case (state)
                ST_WAIT:  qual = hit_a && !(proto == PR_COUNT && ncount == '0);
                ST_RUN: begin
                    case (proto)
                        PR_ALL, PR_START, PR_WINDOW: qual = 1'b1;
                        PR_MATCH, PR_WHILE:          qual = hit_a;
                        PR_STOP:                     qual = !hit_a;
                        default:                     qual = 1'b0;
                    endcase
                end
                ST_COUNT: qual = 1'b1;
                default:  qual = 1'b0;
            endcase
        end
    end

    // R10: nothing qualifies while disarmed
    a_r10_idle_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !qual);

    // R13: arming always leaves the disarmed state
    a_r13_arm_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (state != ST_IDLE && state != ST_COUNT));

    // R8: counting state never holds an exhausted count
    a_r8_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COUNT) |-> (remain != '0));

endmodule

// File: rtl/bcap_store.sv
`timescale 1ns/1ps
module bcap_store #(
    parameter int  DW    = 16,
    parameter int  DEPTH = 1024,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          armed,
    input  logic          cap_req,
    input  logic [DW-1:0] cap_word,
    input  logic          addr_we,
    input  logic [AW-1:0] addr_wdata,
    input  logic          data_we,
    input  logic          data_re,
    input  logic [DW-1:0] data_wdata,
    output logic          full,
    output logic          wr_ok,
    output logic [CW-1:0] wcount,
    output logic [AW-1:0] haddr,
    output logic [DW-1:0] rd_word
);

    logic [DW-1:0] mem [DEPTH];

    assign full    = (wcount == CW'(DEPTH));
    assign wr_ok   = cap_req && armed && !full;
    assign rd_word = mem[haddr];

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wcount[AW-1:0]] <= cap_word;
        end else if (data_we && !armed) begin
            mem[haddr] <= data_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcount <= '0;
        end else if (arm) begin
            wcount <= '0;
        end else if (wr_ok) begin
            wcount <= wcount + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            haddr <= '0;
        end else if (addr_we) begin
            haddr <= addr_wdata;
        end else if (data_we || data_re) begin
            haddr <= haddr + AW'(1);
        end
    end

    // R11: the count never passes the memory depth
    a_r11_count_limit: assert property (@(posedge clk) disable iff (!rst_n)
        wcount <= CW'(DEPTH));

    // R11: once full, the count holds until the next arm
    a_r11_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !arm) |=> $stable(wcount));

    // R13: arming clears the count
    a_r13_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (wcount == '0));

    // R12: a data access steps the host address by one
    a_r12_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_we || data_re) && !addr_we) |=> (haddr == AW'($past(haddr) + AW'(1))));

endmodule

// File: rtl/bus_capture_core.sv
`timescale 1ns/1ps
module bus_capture_core
    import bcap_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_en,
    input  logic [DW-1:0] bus_in,
    input  logic          h_sel,
    input  logic          h_wr,
    input  logic [3:0]    h_addr,
    input  logic [DW-1:0] h_wdata,
    output logic [DW-1:0] h_rdata,
    output logic          cap_valid,
    output logic          full,
    output logic          sig_valid,
    output logic [DW-1:0] sig_data
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    proto_t                    proto_q;
    logic                      store_on, sig_on;
    logic [NUM_PAT-1:0][DW-1:0] pat_val, pat_care;
    logic [DW-1:0]             ncount;
    logic [NUM_PAT-1:0]        hit;
    logic                      host_wr, host_rd, cmd_arm, cmd_disarm;
    logic                      qual, armed, wr_ok;
    logic [CW-1:0]             wcount;
    logic [AW-1:0]             haddr;
    logic [DW-1:0]             rd_word;

    assign host_wr    = h_sel && h_wr;
    assign host_rd    = h_sel && !h_wr;
    assign cmd_arm    = host_wr && (h_addr == RA_CTRL) && h_wdata[CTRL_ARM_BIT];
    assign cmd_disarm = host_wr && (h_addr == RA_CTRL) && h_wdata[CTRL_DISARM_BIT] && !cmd_arm;

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            proto_q  <= PR_ALL;
            store_on <= 1'b0;
            sig_on   <= 1'b0;
            ncount   <= '0;
            pat_val  <= '0;
            pat_care <= '0;
        end else if (host_wr) begin
            if (h_addr == RA_CTRL) begin
                proto_q  <= proto_t'(h_wdata[2:0]);
                store_on <= h_wdata[CTRL_STORE_BIT];
                sig_on   <= h_wdata[CTRL_SIG_BIT];
            end
            if (h_addr == RA_NCNT) ncount <= h_wdata;
            for (int i = 0; i < NUM_PAT; i++) begin
                if (h_addr == RA_PAT_BASE + 4'(2 * i))     pat_val[i]  <= h_wdata;
                if (h_addr == RA_PAT_BASE + 4'(2 * i + 1)) pat_care[i] <= h_wdata;
            end
        end
    end

    bcap_match #(.DW(DW), .NP(NUM_PAT)) u_match (
        .bus  (bus_in),
        .val  (pat_val),
        .care (pat_care),
        .hit  (hit)
    );

    bcap_proto_fsm #(.CNTW(DW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (cmd_arm),
        .disarm    (cmd_disarm),
        .arm_proto (proto_t'(h_wdata[2:0])),
        .proto     (proto_q),
        .smp       (smp_en),
        .hit_a     (hit[0]),
        .hit_b     (hit[1]),
        .ncount    (ncount),
        .qual      (qual),
        .armed     (armed)
    );

    bcap_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (cmd_arm),
        .armed      (armed),
        .cap_req    (qual && store_on),
        .cap_word   (bus_in),
        .addr_we    (host_wr && h_addr == RA_ADDR),
        .addr_wdata (h_wdata[AW-1:0]),
        .data_we    (host_wr && h_addr == RA_DATA),
        .data_re    (host_rd && h_addr == RA_DATA),
        .data_wdata (h_wdata),
        .full       (full),
        .wr_ok      (wr_ok),
        .wcount     (wcount),
        .haddr      (haddr),
        .rd_word    (rd_word)
    );

    // host read mux
    always_comb begin
        h_rdata = '0;
        case (h_addr)
            RA_CTRL: begin
                h_rdata[2:0]           = proto_q;
                h_rdata[CTRL_STORE_BIT] = store_on;
                h_rdata[CTRL_SIG_BIT]   = sig_on;
            end
            RA_STAT: begin
                h_rdata[DW-1]   = armed;
                h_rdata[DW-2]   = full;
                h_rdata[CW-1:0] = wcount;
            end
            RA_ADDR: h_rdata[AW-1:0] = haddr;
            RA_DATA: h_rdata = rd_word;
            RA_NCNT: h_rdata = ncount;
            default: begin
                for (int i = 0; i < NUM_PAT; i++) begin
                    if (h_addr == RA_PAT_BASE + 4'(2 * i))     h_rdata = pat_val[i];
                    if (h_addr == RA_PAT_BASE + 4'(2 * i + 1)) h_rdata = pat_care[i];
                end
            end
        endcase
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid <= 1'b0;
            sig_valid <= 1'b0;
            sig_data  <= '0;
        end else begin
            cap_valid <= wr_ok;
            sig_valid <= qual && sig_on;
            if (qual && sig_on) sig_data <= bus_in;
        end
    end

    // R3: a stored word always follows a sample
    a_r3_valid_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> $past(smp_en));

    // R14: a forwarded word always follows a sample
    a_r14_sig_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid |-> $past(smp_en));

    // R11: no store pulse once the memory was already full
    a_r11_no_store_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !cmd_arm) |=> !cap_valid);

endmodule

// File: tb/bus_capture_core_tb.sv
`timescale 1ns/1ps
module bus_capture_core_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_en = 1'b0, h_sel = 1'b0, h_wr = 1'b0;
    logic [15:0] bus_in = '0, h_wdata = '0;
    logic [3:0]  h_addr = '0;
    logic [15:0] h_rdata, sig_data;
    logic        cap_valid, full, sig_valid;

    always #2.5 clk = ~clk;

    bus_capture_core u_dut (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .bus_in(bus_in),
        .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_rdata(h_rdata), .cap_valid(cap_valid), .full(full),
        .sig_valid(sig_valid), .sig_data(sig_data)
    );

    int    n_chk = 0, n_fail = 0;
    string cur_req = "R1";
    bit    done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int          m_proto, m_state, m_rem, m_cnt, m_haddr;
    bit          m_store, m_sig;
    logic [15:0] m_pv [2];
    logic [15:0] m_pc [2];
    logic [15:0] m_n;
    logic [15:0] m_mem [1024];
    bit          exp_cv, exp_sv;
    logic [15:0] exp_sd;

    function automatic void m_sample(input logic [15:0] b);
        bit h0, h1, q;
        h0 = ((b ^ m_pv[0]) & m_pc[0]) == 16'h0;
        h1 = ((b ^ m_pv[1]) & m_pc[1]) == 16'h0;
        q  = 0;
        case (m_state)
            1: if (h0) begin
                if (m_proto == 5) begin
                    if (m_n == 0) m_state = 4;
                    else begin
                        q = 1;
                        if (m_n == 1) m_state = 4;
                        else begin m_state = 3; m_rem = int'(m_n) - 1; end
                    end
                end else begin
                    q = 1; m_state = 2;
                end
            end
            2: case (m_proto)
                0, 2:    q = 1;
                1:       q = h0;
                3:       if (h0) m_state = 4; else q = 1;
                4:       if (h0) q = 1; else m_state = 4;
                6:       begin q = 1; if (h1) m_state = 4; end
                default: q = 0;
            endcase
            3: begin q = 1; m_rem--; if (m_rem == 0) m_state = 4; end
            default: q = 0;
        endcase
        if (q) begin
            if (m_store && m_cnt < 1024) begin
                m_mem[m_cnt] = b; m_cnt++; exp_cv = 1;
            end
            if (m_sig) begin exp_sv = 1; exp_sd = b; end
        end
    endfunction

    always @(posedge clk) begin
        bit arm_c, dis_c;
        if (!rst_n) begin
            m_proto = 0; m_state = 0; m_rem = 0; m_cnt = 0; m_haddr = 0;
            m_store = 0; m_sig = 0; m_n = 0;
            m_pv[0] = 0; m_pv[1] = 0; m_pc[0] = 0; m_pc[1] = 0;
            exp_cv = 0; exp_sv = 0; exp_sd = 0;
        end else begin
            arm_c  = h_sel && h_wr && h_addr == 0 && h_wdata[15];
            dis_c  = h_sel && h_wr && h_addr == 0 && h_wdata[14] && !arm_c;
            exp_cv = 0; exp_sv = 0;
            if (smp_en && !arm_c && !dis_c && m_state != 0) m_sample(bus_in);
            if (h_sel && h_wr) begin
                case (h_addr)
                    0: begin
                        m_proto = int'(h_wdata[2:0]); m_store = h_wdata[3]; m_sig = h_wdata[4];
                        if (arm_c) begin
                            m_state = (m_proto inside {2, 4, 5, 6}) ? 1 : (m_proto == 7 ? 4 : 2);
                            m_cnt = 0;
                        end else if (dis_c) m_state = 0;
                    end
                    2: m_haddr = int'(h_wdata[9:0]);
                    3: begin
                        if (m_state == 0) m_mem[m_haddr] = h_wdata;
                        m_haddr = (m_haddr + 1) % 1024;
                    end
                    4: m_pv[0] = h_wdata;
                    5: m_pc[0] = h_wdata;
                    6: m_pv[1] = h_wdata;
                    7: m_pc[1] = h_wdata;
                    8: m_n = h_wdata;
                    default: ;
                endcase
            end else if (h_sel && h_addr == 3) begin
                m_haddr = (m_haddr + 1) % 1024;
            end
        end
    end

    // per-clock comparison, away from the edge
    always begin
        @(posedge clk);
        #2;
        if (rst_n) begin
            chk(cap_valid == exp_cv, cur_req, "cap_valid", cap_valid, exp_cv);
            chk(sig_valid == exp_sv, cur_req, "sig_valid", sig_valid, exp_sv);
            chk(full == (m_cnt == 1024), cur_req, "full", full, m_cnt == 1024);
            if (exp_sv) chk(sig_data == exp_sd, cur_req, "sig_data", sig_data, exp_sd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input logic s, input logic w, input logic [3:0] a,
                       input logic [15:0] d, input logic e, input logic [15:0] b);
        @(negedge clk);
        h_sel = s; h_wr = w; h_addr = a; h_wdata = d; smp_en = e; bus_in = b;
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0);
    endtask

    task automatic host_rd(input logic [3:0] a, output logic [15:0] v);
        cyc(1, 0, a, 0, 0, 0);
        #1 v = h_rdata;
    endtask

    function automatic logic [15:0] stream(input int i);
        logic [15:0] t [16] = '{16'h1200, 16'h34A5, 16'h56A5, 16'h0007,
                                16'hF001, 16'h78A5, 16'h9A00, 16'hBCA5,
                                16'hF0A5, 16'hDE11, 16'h11A5, 16'h2222,
                                16'h33A5, 16'h44A5, 16'h5555, 16'hF666};
        return t[i % 16];
    endfunction

    task automatic readback(input string tag);
        logic [15:0] v, es;
        host_rd(1, v);
        es = {m_state != 0, m_cnt == 1024, 3'b000, 11'(m_cnt)};
        chk(v == es, tag, "status", v, es);
        cyc(1, 1, 2, 16'h0000, 0, 0);
        for (int i = 0; i < m_cnt; i++) begin
            host_rd(3, v);
            chk(v == m_mem[i], tag, "memory word", v, m_mem[i]);
        end
        idle();
    endtask

    task automatic run_phase(input string tag, input int proto, input bit st,
                             input bit sg, input int nw);
        logic [15:0] c;
        cur_req = tag;
        c = 16'(proto) | (st ? 16'h0008 : 16'h0) | (sg ? 16'h0010 : 16'h0);
        cyc(1, 1, 0, 16'h4000 | c, 0, 0);
        cyc(1, 1, 0, 16'h8000 | c, 0, 0);
        for (int i = 0; i < nw; i++) cyc(0, 0, 0, 0, (i % 5) != 4, stream(i));
        cyc(1, 1, 0, 16'h4000 | c, 0, 0);
        readback(tag);
    endtask

    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cur_req = "R1";
        host_rd(1, v);
        chk(v == 16'h0000, "R1", "status after reset", v, 0);
        host_rd(5, v);
        chk(v == 16'h0000, "R1", "care mask after reset", v, 0);
        chk(!cap_valid && !sig_valid && !full && sig_data == 0, "R1", "outputs after reset",
            {cap_valid, sig_valid, full}, 0);
        // compare patterns
        cyc(1, 1, 4, 16'h00A5, 0, 0);
        cyc(1, 1, 5, 16'h00FF, 0, 0);
        cyc(1, 1, 6, 16'hF000, 0, 0);
        cyc(1, 1, 7, 16'hF000, 0, 0);
        idle();

        run_phase("R3", 0, 1, 1, 20);
        run_phase("R2 R4", 1, 1, 1, 24);
        run_phase("R5", 2, 1, 0, 20);
        run_phase("R6", 3, 1, 1, 20);
        run_phase("R7", 4, 1, 1, 20);
        cyc(1, 1, 8, 16'd3, 0, 0);
        run_phase("R8", 5, 1, 1, 20);
        cyc(1, 1, 8, 16'd0, 0, 0);
        run_phase("R8", 5, 1, 1, 20);
        run_phase("R9", 6, 1, 1, 24);
        run_phase("R10", 7, 1, 1, 20);
        cur_req = "R10";
        for (int i = 0; i < 6; i++) cyc(0, 0, 0, 0, 1, stream(i));
        readback("R10");
        run_phase("R14", 0, 0, 1, 16);

        // R11: fill memory, then overrun it
        cur_req = "R11";
        cyc(1, 1, 0, 16'h8018, 0, 0);
        for (int i = 0; i < 1030; i++) cyc(0, 0, 0, 0, 1, stream(i));
        idle();
        host_rd(1, v);
        chk(v == 16'hC400, "R11", "status when full", v, 16'hC400);
        cyc(1, 1, 0, 16'h4018, 0, 0);
        readback("R11");

        // R12: auto-increment and wrap
        cur_req = "R12";
        cyc(1, 1, 2, 16'd1022, 0, 0);
        for (int k = 0; k < 4; k++) cyc(1, 1, 3, 16'hC000 + 16'(k), 0, 0);
        host_rd(2, v);
        chk(v == 16'd2, "R12", "address after wrap", v, 2);
        cyc(1, 1, 2, 16'd1022, 0, 0);
        for (int k = 0; k < 4; k++) begin
            host_rd(3, v);
            chk(v == 16'hC000 + 16'(k), "R12", "block read", v, 16'hC000 + 16'(k));
        end
        idle();

        // R13: arm cycle sample dropped; host writes blocked while armed
        cur_req = "R13";
        cyc(1, 1, 0, 16'h8008, 1, 16'hBEEF);
        cyc(0, 0, 0, 0, 1, 16'h1111);
        cyc(1, 1, 0, 16'h4008, 0, 0);
        idle();
        host_rd(1, v);
        chk(v == 16'h0001, "R13", "count after rearm", v, 1);
        cyc(1, 1, 2, 16'd0, 0, 0);
        host_rd(3, v);
        chk(v == 16'h1111, "R13", "first word after rearm", v, 16'h1111);
        cyc(1, 1, 0, 16'h8007, 0, 0);
        cyc(1, 1, 2, 16'd5, 0, 0);
        cyc(1, 1, 3, 16'hDEAD, 0, 0);
        cyc(1, 1, 0, 16'h4007, 0, 0);
        cyc(1, 1, 2, 16'd5, 0, 0);
        host_rd(3, v);
        chk(v == stream(5), "R13", "word untouched by armed write", v, stream(5));
        idle();
        repeat (3) @(negedge clk);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule